// File: doc/BRIEF.md
# CHR Bank and Mirroring Unit

This unit turns pattern-table fetches from the picture processor into addresses for a 128 KB character memory. The 8 KB pattern space is split into eight 1 KB windows. The window is chosen by picture address bits 12..10, and each window has its own 7-bit bank register. The unit also picks which picture address line drives the A10 input of the console's internal nametable RAM. That choice gives horizontal or vertical nametable mirroring.

The CPU programs the bank registers and the mirroring bit with plain single-cycle write strobes. All of these registers sit inside the CPU range $F000-$FFFF, which is also the bank-data port of the separate program-memory mapping logic. The unit raises a bank-data write strobe for every write into that range, including writes that also land in one of its own registers. The program-memory logic therefore receives them unchanged.

Top module: `chr_mirror_unit`

## Requirements
- R1: After synchronous reset all eight bank registers read 0 and mirroring is horizontal. So `chr_addr` equals `{7'd0, ppu_addr[9:0]}` and `ciram_a10` follows `ppu_addr[11]`.
- R2: A write with `cpu_addr[15:10]` = 6'b111111 updates bank register `cpu_addr[2:0]`. Address bits 9..3 are don't-care, so a write to $FDFB updates register 3.
- R3: A bank register stores `cpu_data[6:0]`, and `cpu_data[7]` is discarded. Writing $FF stores $7F.
- R4: `chr_addr` is `{bank[ppu_addr[12:10]], ppu_addr[9:0]}`, a 17-bit address, and it is combinational from the stored banks.
- R5: A write with `cpu_addr[15:10]` = 6'b111110 ($F800-$FBFF) stores `cpu_data[0]` as the mirroring bit. Data bits 7..1 are ignored.
- R6: With mirroring bit 0, `ciram_a10` equals `ppu_addr[11]` (horizontal). With mirroring bit 1, it equals `ppu_addr[10]` (vertical).
- R7: Writes to addresses outside the two decoded ranges, for example $F000, $F400 or $E000, change no bank and not the mirroring bit.
- R8: `bank_data_we` is high in exactly the cycles where `cpu_we` is high and `cpu_addr[15:12]` = 4'hF. This includes writes that also update a bank or the mirroring bit.
- R9: While `cpu_we` is low, no register changes, whatever `cpu_addr` and `cpu_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| cpu_we | input | 1 | Single-cycle CPU write strobe |
| ppu_addr | input | 14 | Picture processor fetch address |
| chr_addr | output | 17 | Translated character memory address |
| ciram_a10 | output | 1 | A10 select for the internal nametable RAM |
| bank_data_we | output | 1 | Bank-data write strobe passed on to the program mapping logic |

## Verification
On every cycle the embedded properties check the following:
- The decoder enables at most one bank register.
- A bank or the mirroring bit takes the written value one edge after its enable, and nothing moves without an enable.
- The bank-data strobe accompanies every write into the character and mirroring ranges.

Some behaviour only the bench scenarios can show, because it depends on the values the CPU chose to write. This covers the aliasing of address bits 9..3, the dropped data bit 7, the left-over data bits of the mirroring register, and the way a stored bank shows up when the picture processor fetches from its window. The reference model covers these by comparing the translated address and the A10 select against its own state on every clock, under random writes and fetch addresses.

// File: rtl/chr_mirror_pkg.sv
package chr_mirror_pkg;

    parameter int CHR_BANKS = 8;
    parameter int BANK_W    = 7;
    parameter int WIN_W     = 10;
    parameter int CPU_AW    = 16;
    parameter int CPU_DW    = 8;
    parameter int PPU_AW    = 14;

    localparam int SEL_W  = $clog2(CHR_BANKS);
    localparam int CHR_AW = BANK_W + WIN_W;
    localparam int PAGE_W = 6;

    localparam logic [PAGE_W-1:0] CHR_PAGE  = 6'b111111;
    localparam logic [PAGE_W-1:0] MIRR_PAGE = 6'b111110;
    localparam logic [3:0]        BDATA_NIB = 4'hF;

    typedef logic [BANK_W-1:0] bank_t;

    typedef enum logic {
        MIRR_HORZ = 1'b0,
        MIRR_VERT = 1'b1
    } mirr_mode_e;

    typedef struct packed {
        logic [CPU_AW-1:0] addr;
        logic [CPU_DW-1:0] data;
        logic              we;
    } cpu_wr_t;

    function automatic logic [PAGE_W-1:0] page_of(input logic [CPU_AW-1:0] a);
        return a[CPU_AW-1 -: PAGE_W];
    endfunction

    function automatic logic [SEL_W-1:0] window_of(input logic [PPU_AW-1:0] p);
        return p[WIN_W +: SEL_W];
    endfunction

endpackage

// File: rtl/chr_wr_decode.sv
module chr_wr_decode
    import chr_mirror_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  cpu_wr_t              wr,
    output logic [CHR_BANKS-1:0] chr_we,
    output logic                 mirr_we,
    output logic                 bank_data_we
);

    logic is_chr;

    always_comb begin
        is_chr       = wr.we && (page_of(wr.addr) == CHR_PAGE);
        mirr_we      = wr.we && (page_of(wr.addr) == MIRR_PAGE);
        bank_data_we = wr.we && (wr.addr[CPU_AW-1 -: 4] == BDATA_NIB);
    end

    for (genvar g = 0; g < CHR_BANKS; g++) begin : g_sel
        assign chr_we[g] = is_chr && (wr.addr[SEL_W-1:0] == SEL_W'(g));
    end

    // R2
    one_bank_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({chr_we, mirr_we}));

    // R8
    bdata_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (|chr_we || mirr_we) |-> bank_data_we);

endmodule

// File: rtl/chr_bank_file.sv
module chr_bank_file
    import chr_mirror_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CHR_BANKS-1:0] chr_we,
    input  logic [CPU_DW-1:0]    wdata,
    output bank_t                bank_q [CHR_BANKS]
);

    for (genvar g = 0; g < CHR_BANKS; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                bank_q[g] <= '0;
            else if (chr_we[g])
                bank_q[g] <= wdata[BANK_W-1:0];
        end

        // R3
        bank_load_chk: assert property (@(posedge clk) disable iff (rst)
            chr_we[g] |=> (bank_q[g] == $past(wdata[BANK_W-1:0])));

        // R9
        bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !chr_we[g] |=> $stable(bank_q[g]));
    end

    // R1
    bank_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> (bank_q[0] == '0));

endmodule

// File: rtl/chr_mirror_ctl.sv
module chr_mirror_ctl
    import chr_mirror_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mirr_we,
    input  logic wbit,
    input  logic ppu_a10,
    input  logic ppu_a11,
    output logic ciram_a10
);

    mirr_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MIRR_HORZ;
        else if (mirr_we)
            mode_q <= mirr_mode_e'(wbit);
    end

    always_comb begin
        unique case (mode_q)
            MIRR_VERT: ciram_a10 = ppu_a10;
            default:   ciram_a10 = ppu_a11;
        endcase
    end

    // R5
    mirr_load_chk: assert property (@(posedge clk) disable iff (rst)
        mirr_we |=> (mode_q == mirr_mode_e'($past(wbit))));

    // R9
    mirr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mirr_we |=> $stable(mode_q));

    // R1
    mirr_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> (mode_q == MIRR_HORZ));

endmodule

// File: rtl/chr_translate.sv
module chr_translate
    import chr_mirror_pkg::*;
(
    input  bank_t               bank_q [CHR_BANKS],
    input  logic [PPU_AW-1:0]   ppu_addr,
    output logic [CHR_AW-1:0]   chr_addr
);

    always_comb begin
        chr_addr = {bank_q[window_of(ppu_addr)], ppu_addr[WIN_W-1:0]};
    end

endmodule

// File: rtl/chr_mirror_unit.sv
module chr_mirror_unit
    import chr_mirror_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_data,
    input  logic        cpu_we,
    input  logic [13:0] ppu_addr,
    output logic [16:0] chr_addr,
    output logic        ciram_a10,
    output logic        bank_data_we
);

    cpu_wr_t              wr;
    logic [CHR_BANKS-1:0] chr_we;
    logic                 mirr_we;
    bank_t                bank_q [CHR_BANKS];

    assign wr = '{addr: cpu_addr, data: cpu_data, we: cpu_we};

    chr_wr_decode u_decode (
        .clk          (clk),
        .rst          (rst),
        .wr           (wr),
        .chr_we       (chr_we),
        .mirr_we      (mirr_we),
        .bank_data_we (bank_data_we)
    );

    chr_bank_file u_banks (
        .clk    (clk),
        .rst    (rst),
        .chr_we (chr_we),
        .wdata  (wr.data),
        .bank_q (bank_q)
    );

    chr_translate u_xlate (
        .bank_q   (bank_q),
        .ppu_addr (ppu_addr),
        .chr_addr (chr_addr)
    );

    chr_mirror_ctl u_mirr (
        .clk       (clk),
        .rst       (rst),
        .mirr_we   (mirr_we),
        .wbit      (wr.data[0]),
        .ppu_a10   (ppu_addr[10]),
        .ppu_a11   (ppu_addr[11]),
        .ciram_a10 (ciram_a10)
    );

endmodule

// File: tb/test_chr_mirror_unit.sv
module test_chr_mirror_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_we = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic [16:0] chr_addr;
    logic        ciram_a10;
    logic        bank_data_we;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int ref_bank [8];
    int ref_mirr;

    always #5 clk = ~clk;

    chr_mirror_unit i_chr_mirror_unit (
        .clk          (clk),
        .rst          (rst),
        .cpu_addr     (cpu_addr),
        .cpu_data     (cpu_data),
        .cpu_we       (cpu_we),
        .ppu_addr     (ppu_addr),
        .chr_addr     (chr_addr),
        .ciram_a10    (ciram_a10),
        .bank_data_we (bank_data_we)
    );

    // Behavioural reference: state updates on each rising edge.
    always @(posedge clk) begin
        if (rst) begin
            foreach (ref_bank[i]) ref_bank[i] = 0;
            ref_mirr = 0;
        end else if (cpu_we) begin
            if ((cpu_addr & 16'hFC00) == 16'hFC00)
                ref_bank[cpu_addr % 8] = cpu_data % 128;
            else if ((cpu_addr & 16'hFC00) == 16'hF800)
                ref_mirr = cpu_data % 2;
        end
    end

    function automatic int exp_chr(input int p);
        return ref_bank[(p / 1024) % 8] * 1024 + (p % 1024);
    endfunction

    function automatic int exp_ciram(input int p);
        return ref_mirr ? (p / 1024) % 2 : (p / 2048) % 2;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R4 chr_addr", int'(chr_addr), exp_chr(int'(ppu_addr)));
            check("R6 ciram_a10", int'(ciram_a10), exp_ciram(int'(ppu_addr)));
            check("R8 bank_data_we", int'(bank_data_we),
                  int'(cpu_we && cpu_addr >= 16'hF000));
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #2;
        cpu_addr = a; cpu_data = d; cpu_we = 1'b1;
        @(posedge clk); #2;
        cpu_we = 1'b0;
    endtask

    task automatic probe(input logic [13:0] p, input int ex_chr, input int ex_c,
                         input string tag);
        @(posedge clk); #2;
        ppu_addr = p;
        @(negedge clk);
        check(tag, int'(chr_addr), ex_chr);
        check(tag, int'(ciram_a10), ex_c);
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R1 reset state
        probe(14'h0C55, 17'h0055, 1, "R1 reset");
        probe(14'h1755, 17'h0355, 0, "R1 reset");
        // R2 and R3
        wr(16'hFC03, 8'hFF);
        probe(14'h0C12, (7'h7F << 10) | 10'h012, 1, "R3 top bit dropped");
        wr(16'hFDFB, 8'h15);
        probe(14'h0C12, (7'h15 << 10) | 10'h012, 1, "R2 aliased decode");
        wr(16'hFC07, 8'h2A);
        probe(14'h1FFF, (7'h2A << 10) | 10'h3FF, 1, "R2 window 7");
        // R5 and R6
        wr(16'hF800, 8'hFE);
        probe(14'h0800, 17'h0000, 1, "R5 upper data bits ignored");
        wr(16'hFBFF, 8'h01);
        probe(14'h0800, 17'h0000, 0, "R6 vertical a11");
        probe(14'h0400, 17'h0000, 1, "R6 vertical a10");
        // R7: writes outside the decoded ranges
        wr(16'hF000, 8'h7F);
        wr(16'hF403, 8'h55);
        wr(16'hE000, 8'h00);
        probe(14'h0C00, (7'h15 << 10), 1, "R7 no change");
        // R9: data on the bus without strobe
        @(posedge clk); #2;
        cpu_addr = 16'hFC03; cpu_data = 8'h01;
        @(posedge clk); #2;
        cpu_addr = 16'hF800; cpu_data = 8'h00;
        @(posedge clk);
        probe(14'h0C00, (7'h15 << 10), 1, "R9 hold");
        // Random traffic, model compared every clock
        for (int n = 0; n < 4000; n++) begin
            @(posedge clk); #2;
            cpu_we   = ($urandom % 3) != 0;
            cpu_addr = ($urandom % 2) ? (16'hF800 | 16'($urandom % 2048))
                                      : 16'($urandom);
            cpu_data = 8'($urandom);
            ppu_addr = 14'($urandom);
        end
        @(posedge clk); #2 cpu_we = 1'b0;
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule